// File: doc/BRIEF.md
# Mailbox Interrupt Controller with MSI / Legacy Delivery Selection

This unit sits inside the register slave of a bus-to-host bridge endpoint. The host writes to a bank of mailbox registers. Each such write raises a one-cycle strobe on `mbox_wr`, and that strobe latches a sticky flag in a status register. A companion enable register masks the flags. The masked flags are OR-ed into a single pending condition, which drives the local interrupt output `local_irq`.

The pending condition also goes to the host, by one of two routes. Two configuration-space control bits select the route, and each route has its own bit. One bit is an interrupt-disable control for the level-style legacy wire. The other bit turns on message-signalled delivery. MSI wins whenever its control is set. Because of this, a handover that turns on the new route before it turns off the old route never loses a request. When the MSI control is set while a request is pending, a fresh MSI request pulse is issued. When the MSI control is cleared while legacy delivery is still allowed, the legacy level rises at once.

Software reaches the status and enable registers through a simple word-wide register port. It reads the flags, writes ones to acknowledge serviced mailboxes, and programs the mask.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: A one on bit n of `mbox_wr` sets status flag n at the next clock edge, whatever the enable register holds.
- R2: A write to byte address 0x3060 clears every status flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R3: When a mailbox strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: A write to byte address 0x3070 loads data bits 15:0 into the enable register. Data bits 31:16 have no effect, and they read back as zero.
- R5: `local_irq` is high exactly when some flag is set and its enable bit is set. It stays high while any other enabled flag is still pending after one flag is cleared.
- R6: With bit 10 of `cfg_command` clear and bit 16 of `cfg_msi_ctrl` clear, `intx_level` follows `local_irq` in the same cycle.
- R7: With bit 16 of `cfg_msi_ctrl` set, `intx_level` is low. `msi_req` is high for exactly one cycle, in the first cycle in which the enabled-pending condition holds.
- R8: In MSI mode, once the enabled-pending condition has dropped, a later re-arming issues another single-cycle `msi_req`.
- R9: Setting the MSI control while a request is pending raises `msi_req` in that same cycle. Clearing it while bit 10 of `cfg_command` is clear raises `intx_level` in that same cycle.
- R10: With bit 10 of `cfg_command` set and the MSI control clear, `intx_level` and `msi_req` stay low, but mailbox strobes still latch flags.
- R11: A read at 0x3060 or 0x3070 returns the register value in bits 15:0 with zeros above. A read at any other address returns zero.
- R12: While `rst_n` is low, both registers clear, and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Byte address for register read and write |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mbox_wr | input | 16 | One strobe per mailbox, high for a cycle when that mailbox is written |
| cfg_command | input | 16 | Configuration command word; bit 10 disables legacy interrupts |
| cfg_msi_ctrl | input | 32 | MSI capability dword; bit 16 enables MSI |
| intx_level | output | 1 | Level-style legacy interrupt |
| msi_req | output | 1 | Single-cycle request to send an MSI message |
| local_irq | output | 1 | Enabled-pending condition toward the local side |

## Verification
The bench makes a mailbox strobe and a clearing write collide on one flag. A design that gave priority to the clear would lose that mailbox event. The bench also performs both handover orders while a request is pending. A design that edge-detected on `pending` alone would miss the pulse when MSI is switched on, and a design that registered the mode would show a one-cycle hole on the legacy wire. Other checks drop and re-arm the pending condition in MSI mode, where a sticky pulse flag would never fire again. Further checks write ones to the unused upper bits of the enable register and read addresses outside the map, to catch widened or aliased decoding.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  localparam int unsigned WORD_W       = 32;
  localparam int unsigned INTX_OFF_BIT = 10;
  localparam int unsigned MSI_ON_BIT   = 16;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_MSI    = 2'd2
  } irq_mode_e;

  // Next value of a sticky flag word: acknowledged bits drop, new events win.
  function automatic logic [WORD_W-1:0] flag_next(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] ack,
    input logic [WORD_W-1:0] evt
  );
    return (cur & ~ack) | evt;
  endfunction

  // Delivery route: message mode has priority so a handover never drops.
  function automatic irq_mode_e pick_mode(input logic intx_off, input logic msi_on);
    if (msi_on)        return MODE_MSI;
    else if (!intx_off) return MODE_LEGACY;
    else               return MODE_OFF;
  endfunction

endpackage

// File: rtl/mbx_status_bank.sv
module mbx_status_bank
  import mbx_irq_pkg::*;
#(
  parameter int unsigned NUM_MBOX    = 16,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned STATUS_ADDR = 'h3060,
  parameter int unsigned ENABLE_ADDR = 'h3070
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr_en,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic [NUM_MBOX-1:0] mbox_wr,
  output logic [NUM_MBOX-1:0] status_q,
  output logic [NUM_MBOX-1:0] enable_q,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                pending
);

  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(ENABLE_ADDR);

  logic                hit_status, hit_enable;
  logic                wr_status, wr_enable;
  logic [NUM_MBOX-1:0] ack_mask;
  logic [WORD_W-1:0]   next_full;

  assign hit_status = (reg_addr == ST_A);
  assign hit_enable = (reg_addr == EN_A);
  assign wr_status  = reg_wr_en && hit_status;
  assign wr_enable  = reg_wr_en && hit_enable;
  assign ack_mask   = wr_status ? reg_wdata[NUM_MBOX-1:0] : '0;
  assign next_full  = flag_next(WORD_W'(status_q), WORD_W'(ack_mask), WORD_W'(mbox_wr));

  generate
    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= next_full[i];
      end
    end
    if (NUM_MBOX < WORD_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^{reg_wdata[WORD_W-1:NUM_MBOX], next_full[WORD_W-1:NUM_MBOX]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         enable_q <= '0;
    else if (wr_enable) enable_q <= reg_wdata[NUM_MBOX-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_status)      reg_rdata[NUM_MBOX-1:0] = status_q;
    else if (hit_enable) reg_rdata[NUM_MBOX-1:0] = enable_q;
  end

  assign pending = |(status_q & enable_q);

  // R1
  mbox_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mbox_wr) |=> ((status_q & $past(mbox_wr)) == $past(mbox_wr)));

  // R2
  clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(status_q) & ~status_q) & ~$past(ack_mask)) == '0));

  // R4
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> (enable_q == $past(reg_wdata[NUM_MBOX-1:0])));

endmodule

// File: rtl/mbx_irq_router.sv
module mbx_irq_router
  import mbx_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pending,
  input  logic [15:0] cfg_command,
  input  logic [31:0] cfg_msi_ctrl,
  output logic        intx_level,
  output logic        msi_req
);

  irq_mode_e mode;
  logic      msi_armed, msi_armed_q, msi_rise;
  logic      unused_cfg;

  assign mode       = pick_mode(cfg_command[INTX_OFF_BIT], cfg_msi_ctrl[MSI_ON_BIT]);
  assign unused_cfg = ^{cfg_command[15:11], cfg_command[9:0],
                        cfg_msi_ctrl[31:17], cfg_msi_ctrl[15:0]};

  assign msi_armed = pending && (mode == MODE_MSI);

  always_ff @(posedge clk) begin
    if (!rst_n) msi_armed_q <= 1'b0;
    else        msi_armed_q <= msi_armed;
  end

  assign msi_rise   = msi_armed && !msi_armed_q;
  assign msi_req    = msi_rise;
  assign intx_level = pending && (mode == MODE_LEGACY);

  // R7
  msi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req);

  // R7
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(intx_level && msi_req));

  // R8
  msi_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> pending);

  // R10
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_command[INTX_OFF_BIT] && !cfg_msi_ctrl[MSI_ON_BIT]) |-> (!intx_level && !msi_req));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int unsigned NUM_MBOX    = 16,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned STATUS_ADDR = 'h3060,
  parameter int unsigned ENABLE_ADDR = 'h3070
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr_en,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_MBOX-1:0] mbox_wr,
  input  logic [15:0]         cfg_command,
  input  logic [31:0]         cfg_msi_ctrl,
  output logic                intx_level,
  output logic                msi_req,
  output logic                local_irq
);

  logic [NUM_MBOX-1:0] status_q, enable_q;
  logic                pending;
  logic                unused_regs;

  assign unused_regs = ^{status_q, enable_q};

  mbx_status_bank #(
    .NUM_MBOX   (NUM_MBOX),
    .ADDR_W     (ADDR_W),
    .STATUS_ADDR(STATUS_ADDR),
    .ENABLE_ADDR(ENABLE_ADDR)
  ) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata),
    .mbox_wr  (mbox_wr),
    .status_q (status_q),
    .enable_q (enable_q),
    .reg_rdata(reg_rdata),
    .pending  (pending)
  );

  mbx_irq_router router_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending     (pending),
    .cfg_command (cfg_command),
    .cfg_msi_ctrl(cfg_msi_ctrl),
    .intx_level  (intx_level),
    .msi_req     (msi_req)
  );

  assign local_irq = pending;

  // R5
  local_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_irq |-> (|status_q));

endmodule

// File: tb/mbx_irq_ctrl_tb.sv
module mbx_irq_ctrl_tb_top;

  localparam logic [15:0] A_ST = 16'h3060;
  localparam logic [15:0] A_EN = 16'h3070;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] mbox_wr = '0;
  logic [15:0] cfg_command = '0;
  logic [31:0] cfg_msi_ctrl = '0;
  logic        intx_level, msi_req, local_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbx_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mbox_wr(mbox_wr),
    .cfg_command(cfg_command), .cfg_msi_ctrl(cfg_msi_ctrl),
    .intx_level(intx_level), .msi_req(msi_req), .local_irq(local_irq)
  );

  // Behavioural reference model
  int unsigned m_flags = 0;
  int unsigned m_mask  = 0;
  bit          m_prev_msi_pend = 0;

  function automatic bit m_pend();
    return (m_flags & m_mask) != 0;
  endfunction
  function automatic bit m_msi_on();
    return cfg_msi_ctrl[16];
  endfunction
  function automatic bit m_leg_on();
    return !cfg_msi_ctrl[16] && !cfg_command[10];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0; m_mask = 0; m_prev_msi_pend = 0;
    end else begin
      m_prev_msi_pend = m_pend() && m_msi_on();
      if (reg_wr_en && reg_addr == A_ST) m_flags = m_flags & ~(reg_wdata & 32'hFFFF);
      if (reg_wr_en && reg_addr == A_EN) m_mask = reg_wdata & 32'hFFFF;
      m_flags = m_flags | mbox_wr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      logic [31:0] exp_rd;
      exp_rd = (reg_addr == A_ST) ? m_flags : (reg_addr == A_EN) ? m_mask : 32'h0;
      check("R5 local_irq", {31'h0, local_irq}, {31'h0, m_pend()});
      check("R6 intx_level", {31'h0, intx_level}, {31'h0, m_pend() && m_leg_on()});
      check("R7 msi_req", {31'h0, msi_req},
            {31'h0, m_pend() && m_msi_on() && !m_prev_msi_pend});
      check("R11 reg_rdata", reg_rdata, exp_rd);
    end
  end

  task automatic cyc(input logic [15:0] mb, input logic wr, input logic [15:0] a,
                     input logic [31:0] wd);
    @(negedge clk);
    mbox_wr = mb; reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
  endtask

  task automatic peek(input logic [15:0] a);
    cyc(16'h0, 1'b0, a, 32'h0);
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    reg_addr = A_ST;
    #1;
    // R12
    check("R12 reset status", reg_rdata, 32'h0);
    check("R12 reset outputs", {29'h0, intx_level, msi_req, local_irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: strobe mailbox 3, enable still zero
    cyc(16'h0008, 1'b0, A_ST, 32'h0);
    peek(A_ST);
    check("R1 flag set", reg_rdata, 32'h0000_0008);
    check("R5 masked", {31'h0, local_irq}, 32'h0);

    // R4: upper bits ignored
    cyc(16'h0, 1'b1, A_EN, 32'hFFFF_0008);
    peek(A_EN);
    check("R4 enable readback", reg_rdata, 32'h0000_0008);
    check("R6 legacy level", {31'h0, intx_level}, 32'h1);

    // R2: writing zero clears nothing, writing one clears
    cyc(16'h0, 1'b1, A_ST, 32'h0000_0000);
    peek(A_ST);
    check("R2 zero write keeps", reg_rdata, 32'h0000_0008);
    cyc(16'h0, 1'b1, A_ST, 32'h0000_0008);
    peek(A_ST);
    check("R2 w1c clears", reg_rdata, 32'h0);
    check("R6 level drops", {31'h0, intx_level}, 32'h0);

    // R3: set and clear collide
    cyc(16'h0008, 1'b1, A_ST, 32'h0000_0008);
    peek(A_ST);
    check("R3 set wins", reg_rdata, 32'h0000_0008);

    // R5: two pending, clear one
    cyc(16'h0010, 1'b1, A_EN, 32'h0000_0018);
    cyc(16'h0, 1'b1, A_ST, 32'h0000_0008);
    peek(A_ST);
    check("R5 other still pending", {31'h0, local_irq}, 32'h1);
    check("R5 status", reg_rdata, 32'h0000_0010);

    // R9: legacy -> MSI while pending
    @(negedge clk);
    cfg_msi_ctrl = 32'h0001_0000;
    #2;
    check("R9 msi on handover", {31'h0, msi_req}, 32'h1);
    check("R7 intx off in msi", {31'h0, intx_level}, 32'h0);
    @(negedge clk);
    cfg_command = 16'h0400;
    #2;
    check("R7 single pulse", {31'h0, msi_req}, 32'h0);

    // R8: drop and re-arm
    cyc(16'h0, 1'b1, A_ST, 32'h0000_FFFF);
    peek(A_ST);
    check("R8 cleared", {31'h0, local_irq}, 32'h0);
    cyc(16'h0008, 1'b0, A_ST, 32'h0);
    peek(A_ST);
    check("R8 new pulse", {31'h0, msi_req}, 32'h1);
    peek(A_ST);
    check("R8 pulse ends", {31'h0, msi_req}, 32'h0);

    // R9: MSI -> legacy
    @(negedge clk);
    cfg_command = 16'h0000;
    #2;
    check("R9 both enabled, msi wins", {31'h0, intx_level}, 32'h0);
    @(negedge clk);
    cfg_msi_ctrl = 32'h0;
    #2;
    check("R9 legacy takes over", {31'h0, intx_level}, 32'h1);

    // R10: neither route
    @(negedge clk);
    cfg_command = 16'h0400;
    cyc(16'h0080, 1'b1, A_EN, 32'h0000_00FF);
    peek(A_ST);
    check("R10 no legacy", {31'h0, intx_level}, 32'h0);
    check("R10 no msi", {31'h0, msi_req}, 32'h0);
    check("R10 still latches", reg_rdata, 32'h0000_0088);

    // R11: unmapped address
    peek(16'h3064);
    check("R11 unmapped zero", reg_rdata, 32'h0);

    // Mixed traffic compared by the model each cycle
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      mbox_wr = 16'(1 << (k % 16)) & {16{k[0]}};
      reg_wr_en = (k % 3 == 0);
      reg_addr = (k % 5 == 0) ? A_EN : A_ST;
      reg_wdata = 32'(k * 37);
      cfg_command = (k % 23 < 8) ? 16'h0400 : 16'h0;
      cfg_msi_ctrl = (k % 17 < 9) ? 32'h0001_0000 : 32'h0;
    end
    @(negedge clk);
    mbox_wr = '0; reg_wr_en = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule